// File: doc/BRIEF.md
# Privileged Status Register Controller

This block keeps the 32-bit status word of a processor core and owns every rule for changing it. The word is loaded with a fixed value at reset, can be rewritten by software only while the core runs in privileged mode, and is forced into a privileged, alternate-bank, interrupt-blocked state whenever an exception or interrupt is entered. Bits that carry no function always read as zero.

Next to the storage sits the interrupt gate. A pending interrupt level is compared with the mask field, and the block bit can shut off every interrupt at once. While that block bit is set, a general exception cannot be taken normally. The block raises a request to escalate into the reset state instead. A user break is exempt from this and is entered as usual. The decoder, the saving of the old word and the vector fetch sit around this block and are not part of it.

Top module: `priv_status_ctrl`

## Requirements
- R1: After reset the status word is 0x700000F0. Bits 30, 29 and 28 and the mask field at bits 7:4 are all ones, and every other bit is zero.
- R2: A software write taken in privileged mode stores only bits 30, 29, 28, 15, 9, 8, 7:4, 1 and 0 of the write data (mask 0x700083F3). It is visible on the next cycle.
- R3: Bit 31 and every other bit outside the writable set always read as 0.
- R4: An exception entry that is taken sets bits 30 (mode), 29 (bank) and 28 (block) in the same clock edge and leaves every other bit unchanged.
- R5: priv_o always equals bit 30 and bank_o always equals bit 29 of the status word.
- R6: While bit 28 is 1, irq_accept_o is 0 for every pending level.
- R7: exc_kind_i encodes 2'b00 general, 2'b01 user break, 2'b10 interrupt and 2'b11 general. A general-kind pulse while bit 28 is 1 drives reset_req_o high in that same cycle, and the status word does not change.
- R8: While bit 28 is 0, irq_accept_o is 1 exactly when irq_level_i is strictly greater than the mask field at bits 7:4.
- R9: If a software write and an exception pulse arrive in the same cycle, the write is dropped and only the exception takes effect.
- R10: A write request while bit 30 is 0 leaves the status word unchanged and raises wr_err_o in that cycle. wr_err_o is 0 in privileged mode.
- R11: An interrupt-kind pulse is entered only when irq_accept_o is 1 in that cycle. Otherwise the status word does not change.
- R12: A user-break pulse while bit 28 is 1 is entered normally (R4) and does not raise reset_req_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 32 | Software write data |
| exc_valid_i | input | 1 | Exception or interrupt entry pulse |
| exc_kind_i | input | 2 | Entry kind: 00 general, 01 user break, 10 interrupt, 11 general |
| irq_level_i | input | IMASK_W | Level of the pending interrupt, 0 when none is pending |
| status_o | output | 32 | Current status word |
| priv_o | output | 1 | Privileged mode flag (bit 30) |
| bank_o | output | 1 | Register bank select flag (bit 29) |
| irq_accept_o | output | 1 | Pending interrupt would be accepted |
| reset_req_o | output | 1 | Request to escalate into the reset state |
| wr_err_o | output | 1 | Write was attempted in user mode |

## Verification
The bench builds the block with its default parameters: a 4-bit mask field at bits 7:4 and a 4-bit level input. At that size every level can be tried against every mask value, so the strict greater-than rule is checked over all 256 pairs, including the equal-value diagonal. The remaining directed scenarios cover the corner cases around the block bit and the mode bit. These are escalation for both general encodings, the user-break exemption, interrupt pulses that are refused, a write racing an exception, and writes refused in user mode.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned POS_MD  = 30;
  localparam int unsigned POS_RB  = 29;
  localparam int unsigned POS_BL  = 28;
  localparam int unsigned POS_FD  = 15;
  localparam int unsigned POS_M   = 9;
  localparam int unsigned POS_Q   = 8;
  localparam int unsigned POS_S   = 1;
  localparam int unsigned POS_T   = 0;

  typedef enum logic [1:0] {
    EXC_GENERAL = 2'b00,
    EXC_UBREAK  = 2'b01,
    EXC_IRQ     = 2'b10,
    EXC_GEN_ALT = 2'b11
  } exc_kind_e;

  function automatic logic [XLEN-1:0] bit_at(input int unsigned pos);
    logic [XLEN-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  function automatic logic [XLEN-1:0] field_at(input int unsigned lsb, input int unsigned w);
    logic [XLEN-1:0] v;
    v = '0;
    for (int unsigned i = 0; i < XLEN; i++) begin
      if (i >= lsb && i < lsb + w) v[i] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/psr_write_filter.sv
module psr_write_filter #(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] WMASK = '1
) (
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            md_i,
  input  logic            exc_busy_i,
  output logic            wr_take_o,
  output logic [XLEN-1:0] wr_val_o,
  output logic            wr_err_o
);
  assign wr_take_o = wr_en_i & md_i & ~exc_busy_i;
  assign wr_val_o  = wr_data_i & WMASK;
  assign wr_err_o  = wr_en_i & ~md_i;
endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
  parameter int unsigned LVL_W = 4
) (
  input  logic             bl_i,
  input  logic [LVL_W-1:0] imask_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             accept_o
);
  assign accept_o = ~bl_i & (level_i > imask_i);
endmodule

// File: rtl/psr_entry_ctrl.sv
module psr_entry_ctrl
  import psr_pkg::*;
(
  input  logic      exc_valid_i,
  input  exc_kind_e exc_kind_i,
  input  logic      bl_i,
  input  logic      irq_accept_i,
  output logic      take_entry_o,
  output logic      escalate_o
);
  logic is_general;

  always_comb begin
    is_general   = (exc_kind_i == EXC_GENERAL) || (exc_kind_i == EXC_GEN_ALT);
    escalate_o   = exc_valid_i & is_general & bl_i;
    take_entry_o = 1'b0;
    if (exc_valid_i) begin
      unique case (exc_kind_i)
        EXC_UBREAK:               take_entry_o = 1'b1;
        EXC_IRQ:                  take_entry_o = irq_accept_i;
        EXC_GENERAL, EXC_GEN_ALT: take_entry_o = ~bl_i;
        default:                  take_entry_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/psr_state_reg.sv
module psr_state_reg #(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RST_VAL = '0,
  parameter logic [XLEN-1:0] ENTRY_SET = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_entry_i,
  input  logic            wr_take_i,
  input  logic [XLEN-1:0] wr_val_i,
  output logic [XLEN-1:0] q_o
);
  logic [XLEN-1:0] q, d;

  always_comb begin
    d = q;
    if (take_entry_i)   d = q | ENTRY_SET;
    else if (wr_take_i) d = wr_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_VAL;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/priv_status_ctrl.sv
module priv_status_ctrl
  import psr_pkg::*;
#(
  parameter int unsigned IMASK_LSB = 4,
  parameter int unsigned IMASK_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [31:0]        wr_data_i,
  input  logic               exc_valid_i,
  input  logic [1:0]         exc_kind_i,
  input  logic [IMASK_W-1:0] irq_level_i,
  output logic [31:0]        status_o,
  output logic               priv_o,
  output logic               bank_o,
  output logic               irq_accept_o,
  output logic               reset_req_o,
  output logic               wr_err_o
);
  localparam logic [XLEN-1:0] ENTRY_SET = bit_at(POS_MD) | bit_at(POS_RB) | bit_at(POS_BL);
  localparam logic [XLEN-1:0] IMASK_FLD = field_at(IMASK_LSB, IMASK_W);
  localparam logic [XLEN-1:0] WMASK = ENTRY_SET | IMASK_FLD | bit_at(POS_FD) | bit_at(POS_M)
                                    | bit_at(POS_Q) | bit_at(POS_S) | bit_at(POS_T);
  localparam logic [XLEN-1:0] RST_VAL = ENTRY_SET | IMASK_FLD;

  logic [XLEN-1:0] q, wr_val;
  logic            wr_take, take_entry;
  exc_kind_e       kind;

  assign kind = exc_kind_e'(exc_kind_i);

  psr_write_filter #(.XLEN(XLEN), .WMASK(WMASK)) u_wr (
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .md_i       (q[POS_MD]),
    .exc_busy_i (exc_valid_i),
    .wr_take_o  (wr_take),
    .wr_val_o   (wr_val),
    .wr_err_o   (wr_err_o)
  );

  psr_irq_gate #(.LVL_W(IMASK_W)) u_irq (
    .bl_i     (q[POS_BL]),
    .imask_i  (q[IMASK_LSB +: IMASK_W]),
    .level_i  (irq_level_i),
    .accept_o (irq_accept_o)
  );

  psr_entry_ctrl u_ent (
    .exc_valid_i  (exc_valid_i),
    .exc_kind_i   (kind),
    .bl_i         (q[POS_BL]),
    .irq_accept_i (irq_accept_o),
    .take_entry_o (take_entry),
    .escalate_o   (reset_req_o)
  );

  psr_state_reg #(.XLEN(XLEN), .RST_VAL(RST_VAL), .ENTRY_SET(ENTRY_SET)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_entry_i (take_entry),
    .wr_take_i    (wr_take),
    .wr_val_i     (wr_val),
    .q_o          (q)
  );

  assign status_o = q;
  assign priv_o   = q[POS_MD];
  assign bank_o   = q[POS_RB];
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int unsigned IMASK_LSB = 4,
  parameter int unsigned IMASK_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic               exc_valid_i,
  input logic [1:0]         exc_kind_i,
  input logic [IMASK_W-1:0] irq_level_i,
  input logic [31:0]        status_o,
  input logic               priv_o,
  input logic               bank_o,
  input logic               irq_accept_o,
  input logic               reset_req_o,
  input logic               wr_err_o
);
  localparam logic [31:0] WMASK = 32'h7000_8303 | (((32'h1 << IMASK_W) - 32'h1) << IMASK_LSB);

  logic entry_seen;
  assign entry_seen = exc_valid_i && !reset_req_o && (exc_kind_i != 2'b10 || irq_accept_o);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & ~WMASK) == 32'h0); // R3
  AST_FLAG_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o == status_o[30] && bank_o == status_o[29]); // R5
  AST_ENTRY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_seen |=> status_o[30:28] == 3'b111); // R4
  AST_BL_BLOCKS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[28] |-> !irq_accept_o); // R6
  AST_ESCALATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_kind_i != 2'b01 && exc_kind_i != 2'b10 && status_o[28]) |-> reset_req_o); // R7
  AST_ESCALATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> $stable(status_o)); // R7
  AST_LEVEL_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[28] |-> (irq_accept_o == (irq_level_i > status_o[IMASK_LSB +: IMASK_W]))); // R8
  AST_USER_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !status_o[30] && !exc_valid_i) |=> $stable(status_o)); // R10
  AST_USER_WR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !status_o[30]) |-> wr_err_o); // R10
  AST_IRQ_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_kind_i == 2'b10 && !irq_accept_o && !wr_en_i) |=> $stable(status_o)); // R11
  AST_UBREAK_NO_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && exc_kind_i == 2'b01) |-> !reset_req_o); // R12
endmodule

bind priv_status_ctrl psr_checker #(.IMASK_LSB(IMASK_LSB), .IMASK_W(IMASK_W)) u_psr_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .exc_valid_i  (exc_valid_i),
  .exc_kind_i   (exc_kind_i),
  .irq_level_i  (irq_level_i),
  .status_o     (status_o),
  .priv_o       (priv_o),
  .bank_o       (bank_o),
  .irq_accept_o (irq_accept_o),
  .reset_req_o  (reset_req_o),
  .wr_err_o     (wr_err_o)
);

// File: tb/tb_priv_status_ctrl.sv
`timescale 1ns/1ps
module tb_priv_status_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        exc_valid_i = 1'b0;
  logic [1:0]  exc_kind_i = 2'b00;
  logic [3:0]  irq_level_i = '0;
  logic [31:0] status_o;
  logic        priv_o, bank_o, irq_accept_o, reset_req_o, wr_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  priv_status_ctrl dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en_i = 0; exc_valid_i = 0; exc_kind_i = 2'b00;
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i); idle();
  endtask

  task automatic swrite(input logic [31:0] v);
    wr_en_i = 1; wr_data_i = v; step();
  endtask

  task automatic exc(input logic [1:0] k);
    exc_valid_i = 1; exc_kind_i = k;
  endtask

  task automatic t_reset();
    irq_level_i = 4'hF; #1;
    check("R1 reset word", status_o, 32'h7000_00F0);
    check("R5 priv at reset", {31'b0, priv_o}, 1);
    check("R5 bank at reset", {31'b0, bank_o}, 1);
    check("R6 no accept at reset", {31'b0, irq_accept_o}, 0);
    check("R7 no escalation idle", {31'b0, reset_req_o}, 0);
  endtask

  task automatic t_write();
    swrite(32'hFFFF_FFFF);
    check("R2 write all ones masked", status_o, 32'h7000_83F3);
    check("R3 reserved zero", status_o & ~32'h7000_83F3, 0);
    swrite(32'h4000_0053);
    check("R2 write value", status_o, 32'h4000_0053);
    check("R5 bank cleared", {31'b0, bank_o}, 0);
    check("R10 no err in priv", {31'b0, wr_err_o}, 0);
  endtask

  task automatic t_irq_sweep();
    int bad = 0;
    for (int m = 0; m < 16; m++) begin
      swrite(32'h4000_0000 | (m << 4));
      for (int l = 0; l < 16; l++) begin
        irq_level_i = l[3:0]; #1;
        if (irq_accept_o !== (l > m)) begin
          bad++;
          check($sformatf("R8 mask=%0d lvl=%0d", m, l), {31'b0, irq_accept_o}, {31'b0, l > m});
        end
      end
    end
    check("R8 sweep mismatches", bad, 0);
  endtask

  task automatic t_bl_mask();
    swrite(32'h5000_0000);
    irq_level_i = 4'hF; #1;
    check("R6 BL masks level 15", {31'b0, irq_accept_o}, 0);
  endtask

  task automatic t_entry_escalate();
    swrite(32'h4000_0301);
    exc(2'b00); #1;
    check("R7 no escalation BL=0", {31'b0, reset_req_o}, 0);
    step();
    check("R4 general entry", status_o, 32'h7000_0301);
    exc(2'b00); #1;
    check("R7 escalation general", {31'b0, reset_req_o}, 1);
    step();
    check("R7 word held", status_o, 32'h7000_0301);
    exc(2'b11); #1;
    check("R7 escalation code 11", {31'b0, reset_req_o}, 1);
    step();
  endtask

  task automatic t_ubreak();
    swrite(32'h5000_0000);
    exc(2'b01); #1;
    check("R12 ubreak no escalation", {31'b0, reset_req_o}, 0);
    step();
    check("R12 ubreak entered", status_o, 32'h7000_0000);
  endtask

  task automatic t_irq_entry();
    swrite(32'h4000_0020);
    irq_level_i = 4'd1; exc(2'b10); step();
    check("R11 refused irq", status_o, 32'h4000_0020);
    irq_level_i = 4'd3; exc(2'b10); step();
    check("R11 accepted irq", status_o, 32'h7000_0020);
  endtask

  task automatic t_priority();
    swrite(32'h4000_0000);
    wr_en_i = 1; wr_data_i = 32'h0; exc(2'b00); step();
    check("R9 exception wins", status_o, 32'h7000_0000);
  endtask

  task automatic t_user();
    swrite(32'h0000_0000);
    check("R5 user mode", {31'b0, priv_o}, 0);
    wr_en_i = 1; wr_data_i = 32'h7000_00F0; #1;
    check("R10 err flag", {31'b0, wr_err_o}, 1);
    step();
    check("R10 write ignored", status_o, 32'h0);
    exc(2'b00); step();
    check("R4 entry from user", status_o, 32'h7000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_write();
    t_irq_sweep();
    t_bl_mask();
    t_entry_escalate();
    t_ubreak();
    t_irq_entry();
    t_priority();
    t_user();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule